// File: doc/BRIEF.md
# Limit Monitor Interrupt Status

This block watches six measured channels and compares each new sample with a programmable upper and lower bound. The channels are the on-die temperature, a shared external channel, three further analog inputs and the supply voltage. The shared external channel carries either a remote temperature sensor or a plain analog voltage. Any out-of-limit result is latched into one of two sticky status bytes, which software reads at addresses 00h and 01h. A bit clears on that read only once the newest sample for its channel is back inside its limits. An interrupt line follows the unmasked status bits, and its polarity can be selected.

Each channel delivers a sample with a one-cycle valid strobe. A limit is written through a small select/data port. The mask bytes, the polarity bit and the external-channel mode are static inputs. A software reset pulse empties both status bytes at once.

Top module: `limit_irq_status`

## Requirements
- R1: While reset is held and in the first cycle after it, both status bytes are zero, read data is zero and the interrupt line is at its inactive level.
- R2: A status bit that has been set stays set until a read of its own register clears it or a software reset occurs. Samples that are back in range do not clear it.
- R3: A read strobe (rd_en_i high with address 00h or 01h) clears, at that clock edge, only those bits of the addressed byte whose channel's most recent evaluation was in range. If a new out-of-limit sample for a bit arrives in the same cycle as the read, that bit stays set.
- R4: A software reset pulse clears both status bytes at the next edge and takes precedence over any event in the same cycle.
- R5: Channel 0 (on-die temperature) is compared as signed two's complement, and only in a cycle where its valid strobe is high. Status byte 1 bit 0 sets when sample > high limit. Bit 1 sets when sample <= low limit.
- R6: In sensor mode (ext_volt_mode_i=0), channel 1 is compared as signed. Bit 2 sets when sample > high limit, and bit 3 sets when sample <= low limit. In voltage mode, channel 1 is unsigned and bit 2 sets when sample > high limit or sample <= low limit. Bit 3 never sets in voltage mode.
- R7: In sensor mode, bit 4 of status byte 1 sets in every cycle in which ext_fault_i is high. Its in-range state for the clear rule is the fault level from the previous cycle. In voltage mode the fault input has no effect.
- R8: Channels 2, 3 and 4 are unsigned. Each sets status byte 1 bit 5, 6 or 7 respectively when sample > high limit or sample <= low limit.
- R9: Channel 5 (supply) uses the same unsigned window test and drives status byte 2 bit 4. The other bits of byte 2 are always zero. A read at any address other than 00h or 01h returns zero and clears nothing.
- R10: Limit select s = 2*channel + (0 for high, 1 for low). After reset, channel 0 limits are 50h and F6h (-10), channel 1 limits are FFh (-1) and 00h, and channels 2 to 5 limits are FFh and 00h.
- R11: Let the active condition be a status byte 1 bit set with a zero in mask1_i at the same position, or status byte 2 bit 4 set with mask2_i[4] zero. irq_o equals that condition when irq_pol_i=1 and its inverse when irq_pol_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| meas_valid_i | input | 6 | Per-channel sample strobe |
| meas_data_i | input | 48 | Samples, channel c in bits [8c+7:8c] |
| lim_we_i | input | 1 | Limit write enable |
| lim_sel_i | input | 4 | Limit select (2*channel + low) |
| lim_wdata_i | input | 8 | Limit write value |
| mask1_i | input | 8 | Interrupt mask for status byte 1 |
| mask2_i | input | 8 | Interrupt mask for status byte 2 |
| ext_volt_mode_i | input | 1 | 1: external channel is an analog voltage |
| ext_fault_i | input | 1 | External sensor open/short flag |
| irq_pol_i | input | 1 | 1: interrupt active high |
| sw_rst_i | input | 1 | Software reset pulse |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data |
| status1_o | output | 8 | Status byte 1 |
| status2_o | output | 8 | Status byte 2 |
| irq_o | output | 1 | Interrupt line |

## Verification
A clear-on-read and a fresh out-of-limit sample for the same bit can land in the same cycle. The same is true of a software reset and a new event. The bench drives the read strobe together with a sample above the high limit, after an in-range sample has armed the clear, and expects the bit to survive. It then pulses the software reset together with an out-of-limit sample and expects both bytes to read zero. It also sweeps every 8-bit sample value on every channel and every mask value under both polarities, and checks each against arithmetic comparisons in the bench.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam int NCH    = 6;
  localparam int CH_INT = 0;
  localparam int CH_EXT = 1;
  localparam int CH_A2  = 2;
  localparam int CH_VDD = 5;
  localparam int NLIM   = 2 * NCH;
  localparam int NBIT   = 9;   // 8 bits of byte 1, supply flag at index 8
  localparam int B_VDD  = 8;
  localparam logic [7:0] ADDR_ST1 = 8'h00;
  localparam logic [7:0] ADDR_ST2 = 8'h01;
endpackage

// File: rtl/lim_regfile.sv
module lim_regfile import lim_pkg::*; #(
  parameter int DW = 8,
  localparam int SW = $clog2(NLIM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SW-1:0]     sel_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NCH*DW-1:0] hi_o,
  output logic [NCH*DW-1:0] lo_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [DW-1:0] HI_RST = (c == CH_INT) ? DW'(80)  : {DW{1'b1}};
    localparam logic [DW-1:0] LO_RST = (c == CH_INT) ? DW'(-10) : {DW{1'b0}};
    logic [DW-1:0] hi_q, lo_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q <= HI_RST;
        lo_q <= LO_RST;
      end else if (we_i) begin
        if (sel_i == SW'(2*c))     hi_q <= wdata_i;
        if (sel_i == SW'(2*c + 1)) lo_q <= wdata_i;
      end
    end
    assign hi_o[c*DW +: DW] = hi_q;
    assign lo_o[c*DW +: DW] = lo_q;
  end
endmodule

// File: rtl/lim_cmp.sv
module lim_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  input  logic          signed_i,
  output logic          above_o,
  output logic          low_o
);
  always_comb begin
    if (signed_i) begin
      above_o = $signed(val_i) >  $signed(hi_i);
      low_o   = $signed(val_i) <= $signed(lo_i);
    end else begin
      above_o = val_i >  hi_i;
      low_o   = val_i <= lo_i;
    end
  end
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core import lim_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCH-1:0]  above_i,
  input  logic [NCH-1:0]  low_i,
  input  logic [NCH-1:0]  valid_i,
  input  logic            volt_mode_i,
  input  logic            fault_i,
  input  logic            sw_rst_i,
  input  logic            rd1_i,
  input  logic            rd2_i,
  output logic [NBIT-1:0] st_o
);
  logic [NBIT-1:0] cnd, vld, clr, st_q, cond_q;

  always_comb begin
    cnd[0] = above_i[CH_INT];
    vld[0] = valid_i[CH_INT];
    cnd[1] = low_i[CH_INT];
    vld[1] = valid_i[CH_INT];
    cnd[2] = above_i[CH_EXT] | (volt_mode_i & low_i[CH_EXT]);
    vld[2] = valid_i[CH_EXT];
    cnd[3] = ~volt_mode_i & low_i[CH_EXT];
    vld[3] = valid_i[CH_EXT];
    cnd[4] = ~volt_mode_i & fault_i;   // fault is a level, evaluated every cycle
    vld[4] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cnd[5+k] = above_i[CH_A2+k] | low_i[CH_A2+k];
      vld[5+k] = valid_i[CH_A2+k];
    end
    cnd[B_VDD] = above_i[CH_VDD] | low_i[CH_VDD];
    vld[B_VDD] = valid_i[CH_VDD];
    clr = {rd2_i, {8{rd1_i}}} & ~cond_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      cond_q <= '0;
    end else if (sw_rst_i) begin
      st_q   <= '0;
      cond_q <= '0;
    end else begin
      st_q <= (st_q & ~clr) | (vld & cnd);
      for (int b = 0; b < NBIT; b++)
        if (vld[b]) cond_q[b] <= cnd[b];
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/limit_irq_status.sv
module limit_irq_status import lim_pkg::*; #(
  parameter int DW = 8,
  localparam int SW = $clog2(NLIM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    meas_valid_i,
  input  logic [NCH*DW-1:0] meas_data_i,
  input  logic              lim_we_i,
  input  logic [SW-1:0]     lim_sel_i,
  input  logic [DW-1:0]     lim_wdata_i,
  input  logic [7:0]        mask1_i,
  input  logic [7:0]        mask2_i,
  input  logic              ext_volt_mode_i,
  input  logic              ext_fault_i,
  input  logic              irq_pol_i,
  input  logic              sw_rst_i,
  input  logic              rd_en_i,
  input  logic [7:0]        rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [7:0]        status1_o,
  output logic [7:0]        status2_o,
  output logic              irq_o
);
  logic [NCH*DW-1:0] hi, lo;
  logic [NCH-1:0]    above, low;
  logic [NBIT-1:0]   st;
  logic              rd1, rd2, active;

  lim_regfile #(.DW(DW)) i_regs (
    .clk_i, .rst_ni, .we_i(lim_we_i), .sel_i(lim_sel_i), .wdata_i(lim_wdata_i),
    .hi_o(hi), .lo_o(lo)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    logic sgn;
    if (c == CH_INT) begin : g_s
      assign sgn = 1'b1;
    end else if (c == CH_EXT) begin : g_m
      assign sgn = ~ext_volt_mode_i;
    end else begin : g_u
      assign sgn = 1'b0;
    end
    lim_cmp #(.DW(DW)) i_cmp (
      .val_i(meas_data_i[c*DW +: DW]), .hi_i(hi[c*DW +: DW]), .lo_i(lo[c*DW +: DW]),
      .signed_i(sgn), .above_o(above[c]), .low_o(low[c])
    );
  end

  assign rd1 = rd_en_i && (rd_addr_i == ADDR_ST1);
  assign rd2 = rd_en_i && (rd_addr_i == ADDR_ST2);

  irq_status_core i_core (
    .clk_i, .rst_ni, .above_i(above), .low_i(low), .valid_i(meas_valid_i),
    .volt_mode_i(ext_volt_mode_i), .fault_i(ext_fault_i), .sw_rst_i,
    .rd1_i(rd1), .rd2_i(rd2), .st_o(st)
  );

  assign status1_o = st[7:0];
  assign status2_o = {3'b000, st[B_VDD], 4'b0000};

  always_comb begin
    unique case (rd_addr_i)
      ADDR_ST1: rd_data_o = status1_o;
      ADDR_ST2: rd_data_o = status2_o;
      default:  rd_data_o = 8'h00;
    endcase
  end

  assign active = |(status1_o & ~mask1_i) | (status2_o[4] & ~mask2_i[4]);
  assign irq_o  = irq_pol_i ? active : ~active;
endmodule

// File: rtl/limit_irq_status_chk.sv
module limit_irq_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sw_rst_i,
  input logic       rd_en_i,
  input logic [7:0] rd_addr_i,
  input logic       ext_volt_mode_i,
  input logic       ext_fault_i,
  input logic       irq_pol_i,
  input logic [7:0] status1_o,
  input logic [7:0] status2_o,
  input logic       irq_o
);
  p_swrst_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (status1_o == 8'h00 && status2_o == 8'h00));

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_rst_i && !rd_en_i) |=>
      (((status1_o & $past(status1_o)) == $past(status1_o)) &&
       ((status2_o & $past(status2_o)) == $past(status2_o))));

  p_fault_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_rst_i && ext_fault_i && !ext_volt_mode_i) |=> status1_o[4]);

  p_rd_keep_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == 8'h00 && !sw_rst_i && ext_fault_i && !ext_volt_mode_i)
      |=> status1_o[4]);

  p_idle_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status1_o == 8'h00 && status2_o == 8'h00) |-> (irq_o == !irq_pol_i));
endmodule

bind limit_irq_status limit_irq_status_chk i_chk (.*);

// File: tb/test_limit_irq_status.sv
`timescale 1ns/1ps
module test_limit_irq_status;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  meas_valid_i = '0;
  logic [47:0] meas_data_i = '0;
  logic        lim_we_i = 1'b0;
  logic [3:0]  lim_sel_i = '0;
  logic [7:0]  lim_wdata_i = '0;
  logic [7:0]  mask1_i = '0;
  logic [7:0]  mask2_i = '0;
  logic        ext_volt_mode_i = 1'b0;
  logic        ext_fault_i = 1'b0;
  logic        irq_pol_i = 1'b1;
  logic        sw_rst_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o, status1_o, status2_o;
  logic        irq_o;

  int n_vec = 0, n_bad = 0;
  string req = "R1";
  logic [7:0] lim [12];
  logic [8:0] est, econd;

  always #5 clk_i = ~clk_i;

  limit_irq_status i_limit_irq_status (.*);

  function automatic logic [1:0] cmpf(input logic [7:0] v, h, l, input logic s);
    if (s) return {$signed(v) > $signed(h), $signed(v) <= $signed(l)};
    return {v > h, v <= l};
  endfunction

  task automatic model_reset();
    est = '0; econd = '0;
    for (int c = 0; c < 6; c++) begin
      lim[2*c]   = (c == 0) ? 8'h50 : 8'hFF;
      lim[2*c+1] = (c == 0) ? 8'hF6 : 8'h00;
    end
  endtask

  task automatic check_now();
    logic act, exp_irq;
    logic [7:0] e1, e2, erd;
    e1 = est[7:0];
    e2 = {3'b0, est[8], 4'b0};
    erd = (rd_addr_i == 8'h00) ? e1 : (rd_addr_i == 8'h01) ? e2 : 8'h00;
    act = |(e1 & ~mask1_i) | (est[8] & ~mask2_i[4]);
    exp_irq = irq_pol_i ? act : ~act;
    n_vec++;
    if (status1_o !== e1 || status2_o !== e2 || irq_o !== exp_irq || rd_data_o !== erd) begin
      n_bad++;
      $display("FAIL %s: st1=%h st2=%h irq=%b rd=%h expected st1=%h st2=%h irq=%b rd=%h",
               req, status1_o, status2_o, irq_o, rd_data_o, e1, e2, exp_irq, erd);
    end
  endtask

  task automatic tick();
    logic [1:0] r [6];
    logic [8:0] v, c, clr;
    @(posedge clk_i);
    for (int ch = 0; ch < 6; ch++)
      r[ch] = cmpf(meas_data_i[8*ch +: 8], lim[2*ch], lim[2*ch+1],
                   (ch == 0) || (ch == 1 && !ext_volt_mode_i));
    c[0] = r[0][1]; v[0] = meas_valid_i[0];
    c[1] = r[0][0]; v[1] = meas_valid_i[0];
    c[2] = ext_volt_mode_i ? (r[1][1] | r[1][0]) : r[1][1]; v[2] = meas_valid_i[1];
    c[3] = !ext_volt_mode_i && r[1][0]; v[3] = meas_valid_i[1];
    c[4] = !ext_volt_mode_i && ext_fault_i; v[4] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      c[5+k] = |r[2+k]; v[5+k] = meas_valid_i[2+k];
    end
    c[8] = |r[5]; v[8] = meas_valid_i[5];
    clr = {rd_en_i && rd_addr_i == 8'h01, {8{rd_en_i && rd_addr_i == 8'h00}}} & ~econd;
    if (sw_rst_i) begin
      est = '0; econd = '0;
    end else begin
      est = (est & ~clr) | (v & c);
      econd = (econd & ~v) | (c & v);
    end
    if (lim_we_i) lim[lim_sel_i] = lim_wdata_i;
    @(negedge clk_i);
    check_now();
  endtask

  task automatic idle();
    meas_valid_i = '0; rd_en_i = 1'b0; lim_we_i = 1'b0; sw_rst_i = 1'b0;
  endtask

  task automatic meas(input int ch, input logic [7:0] val);
    idle();
    meas_valid_i[ch] = 1'b1;
    meas_data_i[8*ch +: 8] = val;
    tick();
  endtask

  task automatic rd(input logic [7:0] a);
    idle(); rd_en_i = 1'b1; rd_addr_i = a; tick(); rd_en_i = 1'b0;
  endtask

  task automatic set_lim(input int s, input logic [7:0] val);
    idle(); lim_we_i = 1'b1; lim_sel_i = 4'(s); lim_wdata_i = val; tick(); lim_we_i = 1'b0;
  endtask

  task automatic sweep(input int ch);
    logic [7:0] a;
    a = (ch == 5) ? 8'h01 : 8'h00;
    for (int x = 0; x < 256; x++) begin
      meas(ch, 8'(x));
      rd(a);             // out-of-range sample keeps bit set
      meas(ch, 8'h20);   // in range
      rd(a);             // now clears
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end

  initial begin
    model_reset();
    req = "R1";
    repeat (3) @(negedge clk_i);
    check_now();
    rst_ni = 1'b1;
    idle(); tick();

    // R10: reset limits
    req = "R10"; meas(1, 8'h00);               // 0 > -1 and 0 <= 0
    meas(2, 8'h00); meas(3, 8'hFF); meas(5, 8'h80);
    meas(0, 8'h50); meas(0, 8'h51);
    // R4: software reset beats a same-cycle event
    req = "R4"; idle(); sw_rst_i = 1'b1; meas_valid_i[0] = 1'b1;
    meas_data_i[7:0] = 8'h7F; tick(); idle(); tick();

    // program narrow windows on all channels
    for (int ch = 0; ch < 6; ch++) begin
      set_lim(2*ch, 8'h30); set_lim(2*ch+1, 8'h10);
    end
    // R5, R6, R8, R9 sweeps
    req = "R5"; sweep(0);
    req = "R6"; ext_volt_mode_i = 1'b0; sweep(1);
    ext_volt_mode_i = 1'b1; sweep(1); ext_volt_mode_i = 1'b0;
    req = "R8"; sweep(2); sweep(3); sweep(4);
    req = "R9"; sweep(5);
    meas(5, 8'hF0); rd(8'h02); rd(8'h7F); meas(5, 8'h20); rd(8'h01);

    // R2: in-range samples do not clear
    req = "R2"; meas(0, 8'h40); meas(0, 8'h20); tick(); tick(); rd(8'h00);
    // R3: read together with a fresh event keeps the bit
    req = "R3"; meas(0, 8'h40); meas(0, 8'h20);
    idle(); rd_en_i = 1'b1; rd_addr_i = 8'h00; meas_valid_i[0] = 1'b1;
    meas_data_i[7:0] = 8'h40; tick(); idle();
    meas(0, 8'h20); rd(8'h00);

    // R7: fault flag
    req = "R7"; idle(); ext_fault_i = 1'b1; tick(); tick(); rd(8'h00);
    ext_fault_i = 1'b0; rd(8'h00); tick(); rd(8'h00);
    ext_volt_mode_i = 1'b1; ext_fault_i = 1'b1; tick(); tick();
    ext_fault_i = 1'b0; ext_volt_mode_i = 1'b0; tick();

    // R11: mask and polarity sweep with both bytes holding bits
    req = "R11"; meas(2, 8'h00); meas(0, 8'h40); meas(5, 8'hFF);
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 512; m++) begin
        @(negedge clk_i);
        irq_pol_i = p[0]; mask1_i = m[7:0]; mask2_i = {3'b0, m[8], 4'b0};
        #1 check_now();
      end
    irq_pol_i = 1'b0; mask1_i = '0; mask2_i = '0;
    req = "R4"; idle(); sw_rst_i = 1'b1; tick(); idle(); tick();
    req = "R11"; tick();
    report();
  end
endmodule